// File: doc/BRIEF.md
# Serial CRC-4 Frame Sealer

This block computes a 4-bit cyclic redundancy check over a 32-bit frame, most significant bit first. The frame's four least significant bit positions are the CRC field. While the CRC is worked out, those positions are fed in as zeros. After all 32 bit times have been clocked, the result is spliced into those positions. The CRC register is seeded with all ones at every frame start and follows the polynomial x^4 + x + 1.

Bits can arrive one at a time on a serial input qualified by a valid strobe, opened by a frame start strobe. A whole 32-bit word can also be loaded in one cycle, and the block then walks through it internally at one bit per clock. Each finished frame produces a one-cycle done pulse. The computed CRC and the sealed frame (upper 28 received bits followed by the CRC) are held until the next frame completes.

In check mode the block compares the computed CRC with the low nibble it actually received. It then raises a one-cycle match or mismatch flag alongside the done pulse. A receiver can use this flag to reject a corrupted word.

Top module: `crc4_frame_seal`

## Requirements
- R1: While reset is applied and in the first cycle after it, done_o, crc_ok_o and crc_err_o are low, and crc_o and frame_o are zero.
- R2: At every frame start the CRC register is seeded with 4'b1111. For each accepted bit b, with f = b XOR crc[3], the next register is {crc[2], crc[1], crc[0] XOR f, f}.
- R3: Bits are taken most significant first. The cycle after the 32nd accepted bit, done_o is high for exactly one cycle and crc_o holds the result. crc_o and frame_o change only when done_o rises.
- R4: Bit positions 3..0 of the frame enter the calculation as zeros, whatever their value. frame_o is the 28 received upper bits in [31:4] with the CRC in [3:0].
- R5: Frame 32'h007D8300 gives CRC 4'h3 (sealed 32'h007D8303). Frame 32'h0F000400 gives CRC 4'h7 (sealed 32'h0F000407).
- R6: If mode_chk_i is high at frame start, done_o comes with crc_ok_o when the received bits [3:0] equal the computed CRC, or else with crc_err_o. In generate mode (mode_chk_i low) both flags stay low.
- R7: A frame start at any point seeds the register again and discards the bits already taken for the unfinished frame.
- R8: When start_i and bit_vld_i are high in the same cycle, that bit is taken as bit 31 of the new frame.
- R9: bit_vld_i has no effect when no serial frame is open (after reset, after a frame completes) or while a loaded word is being processed.
- R10: word_load_i opens a frame from word_i. It outranks start_i in the same cycle and aborts any open frame. done_o follows on the 32nd clock edge after the load edge.
- R11: Cycles with bit_vld_i low inside a serial frame do not advance it. The result depends only on the accepted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens a serial frame and seeds the CRC |
| mode_chk_i | input | 1 | Sampled at frame open: 1 = check received nibble, 0 = generate |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Qualifies bit_i |
| word_load_i | input | 1 | Loads word_i as a frame to walk internally |
| word_i | input | 32 | Parallel frame word |
| crc_o | output | 4 | CRC of the last completed frame |
| done_o | output | 1 | One-cycle completion pulse |
| frame_o | output | 32 | Last completed frame with the CRC in bits 3..0 |
| crc_ok_o | output | 1 | Check mode: received nibble matched |
| crc_err_o | output | 1 | Check mode: received nibble differed |

## Verification
A corrupted CRC register or a skipped or repeated bit shows up at crc_o and frame_o[3:0] only at the next done pulse, up to 32 accepted bits later. A bit counter that is off moves the done pulse by one or more cycles, and that is visible at once in the cycle-exact comparison. A mode latch or zero-fill fault shows as a wrong ok/err flag or a CRC that depends on the received low nibble. The reference vectors, nibble-insensitivity frames and paired good/bad check frames are placed to expose these faults within one frame.

// File: rtl/crc4_pkg.sv
package crc4_pkg;

    localparam int CRC_W = 4;

    typedef logic [CRC_W-1:0] crc_t;

    // Seed and feedback taps (x^4 + x + 1 -> low taps 0011)
    localparam crc_t CRC_SEED = '1;
    localparam crc_t CRC_TAPS = crc_t'(4'b0011);

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_PINS,
        SRC_WORD
    } src_e;

    // One bit offered to the datapath in a given cycle
    typedef struct packed {
        logic vld;   // a bit is consumed this cycle
        logic raw;   // bit as received
        logic fill;  // bit sits in the CRC field: calculate with zero
        logic last;  // final bit of the frame
    } beat_t;

    function automatic crc_t crc_advance(crc_t cur, logic din, crc_t taps);
        logic fb;
        fb = din ^ cur[CRC_W-1];
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? taps : '0);
    endfunction

endpackage

// File: rtl/crc4_seq.sv
module crc4_seq
    import crc4_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               word_load_i,
    input  logic [FRAME_W-1:0] word_i,
    input  logic               bit_i,
    input  logic               bit_vld_i,
    input  logic               mode_chk_i,
    output beat_t              beat_o,
    output logic               restart_o,
    output logic               chk_o
);

    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int FILL_AT = FRAME_W - CRC_W;

    src_e               src_q, src_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d, idx;
    logic [FRAME_W-1:0] word_q, word_d;
    logic               chk_q, chk_d;

    always_comb begin
        src_d     = src_q;
        cnt_d     = cnt_q;
        word_d    = word_q;
        chk_d     = chk_q;
        idx       = cnt_q;
        beat_o    = '0;
        restart_o = start_i | word_load_i;

        if (word_load_i) begin
            // word load wins; its first bit is walked on the next cycle
            src_d  = SRC_WORD;
            cnt_d  = '0;
            word_d = word_i;
            chk_d  = mode_chk_i;
        end else begin
            if (start_i) begin
                src_d = SRC_PINS;
                cnt_d = '0;
                idx   = '0;
                chk_d = mode_chk_i;
            end
            case (src_d)
                SRC_PINS: begin
                    beat_o.vld = bit_vld_i;
                    beat_o.raw = bit_i;
                end
                SRC_WORD: begin
                    beat_o.vld = 1'b1;
                    beat_o.raw = word_q[FRAME_W-1];
                    word_d     = {word_q[FRAME_W-2:0], 1'b0};
                end
                default: ;
            endcase
        end

        beat_o.fill = (idx >= CNT_W'(FILL_AT));
        beat_o.last = (idx == CNT_W'(FRAME_W - 1));

        if (beat_o.vld) begin
            cnt_d = idx + CNT_W'(1);
            if (beat_o.last) begin
                src_d = SRC_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= SRC_NONE;
            cnt_q  <= '0;
            word_q <= '0;
            chk_q  <= 1'b0;
        end else begin
            src_q  <= src_d;
            cnt_q  <= cnt_d;
            word_q <= word_d;
            chk_q  <= chk_d;
        end
    end

    assign chk_o = chk_q;

endmodule

// File: rtl/crc4_lfsr.sv
module crc4_lfsr
    import crc4_pkg::*;
#(
    parameter crc_t TAPS = CRC_TAPS,
    parameter crc_t SEED = CRC_SEED
) (
    input  logic clk,
    input  logic rst,
    input  logic init_i,
    input  logic step_i,
    input  logic din_i,
    output crc_t crc_next_o
);

    crc_t state_q;
    crc_t base;

    always_comb begin
        base       = init_i ? SEED : state_q;
        crc_next_o = step_i ? crc_advance(base, din_i, TAPS) : base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else begin
            state_q <= crc_next_o;
        end
    end

endmodule

// File: rtl/crc4_seal.sv
module crc4_seal
    import crc4_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  beat_t              beat_i,
    input  logic               chk_i,
    input  crc_t               crc_next_i,
    output crc_t               crc_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               done_o,
    output logic               ok_o,
    output logic               err_o
);

    logic [FRAME_W-2:0] hist_q;
    logic [FRAME_W-1:0] full;
    crc_t               rx_nib;

    assign full   = {hist_q, beat_i.raw};
    assign rx_nib = full[CRC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            crc_o   <= '0;
            frame_o <= '0;
            done_o  <= 1'b0;
            ok_o    <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            ok_o   <= 1'b0;
            err_o  <= 1'b0;
            if (beat_i.vld) begin
                hist_q <= full[FRAME_W-2:0];
                if (beat_i.last) begin
                    done_o  <= 1'b1;
                    crc_o   <= crc_next_i;
                    frame_o <= {full[FRAME_W-1:CRC_W], crc_next_i};
                    ok_o    <= chk_i & (rx_nib == crc_next_i);
                    err_o   <= chk_i & (rx_nib != crc_next_i);
                end
            end
        end
    end

endmodule

// File: rtl/crc4_frame_seal.sv
module crc4_frame_seal
    import crc4_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               mode_chk_i,
    input  logic               bit_i,
    input  logic               bit_vld_i,
    input  logic               word_load_i,
    input  logic [FRAME_W-1:0] word_i,
    output logic [CRC_W-1:0]   crc_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               crc_ok_o,
    output logic               crc_err_o
);

    beat_t beat;
    logic  restart;
    logic  chk_mode;
    crc_t  crc_next;

    crc4_seq #(.FRAME_W(FRAME_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .word_load_i (word_load_i),
        .word_i      (word_i),
        .bit_i       (bit_i),
        .bit_vld_i   (bit_vld_i),
        .mode_chk_i  (mode_chk_i),
        .beat_o      (beat),
        .restart_o   (restart),
        .chk_o       (chk_mode)
    );

    crc4_lfsr #(.TAPS(CRC_TAPS), .SEED(CRC_SEED)) u_lfsr (
        .clk        (clk),
        .rst        (rst),
        .init_i     (restart),
        .step_i     (beat.vld),
        .din_i      (beat.raw & ~beat.fill),
        .crc_next_o (crc_next)
    );

    crc4_seal #(.FRAME_W(FRAME_W)) u_seal (
        .clk        (clk),
        .rst        (rst),
        .beat_i     (beat),
        .chk_i      (chk_mode),
        .crc_next_i (crc_next),
        .crc_o      (crc_o),
        .frame_o    (frame_o),
        .done_o     (done_o),
        .ok_o       (crc_ok_o),
        .err_o      (crc_err_o)
    );

endmodule

// File: rtl/crc4_frame_seal_chk.sv
module crc4_frame_seal_chk #(
    parameter int FRAME_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               mode_chk_i,
    input logic               word_load_i,
    input logic [3:0]         crc_o,
    input logic               done_o,
    input logic [FRAME_W-1:0] frame_o,
    input logic               crc_ok_o,
    input logic               crc_err_o
);

    localparam int CNT_W = $clog2(FRAME_W + 1);

    logic             armed;
    logic             wrun;
    logic [CNT_W-1:0] wcnt;
    logic             chk_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            wrun  <= 1'b0;
            wcnt  <= '0;
            chk_m <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (word_load_i) begin
                wrun  <= 1'b1;
                wcnt  <= '0;
                chk_m <= mode_chk_i;
            end else if (start_i) begin
                wrun  <= 1'b0;
                chk_m <= mode_chk_i;
            end else if (wrun) begin
                if (wcnt == CNT_W'(FRAME_W)) wrun <= 1'b0;
                else                         wcnt <= wcnt + CNT_W'(1);
            end
        end
    end

    // R6: a frame cannot both match and mismatch
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(crc_ok_o && crc_err_o));

    // R6: a verdict only comes with completion
    a_r6_flag_needs_done: assert property (@(posedge clk) disable iff (rst)
        (crc_ok_o || crc_err_o) |-> done_o);

    // R6: generate mode never raises a verdict
    a_r6_gen_silent: assert property (@(posedge clk) disable iff (rst)
        (done_o && !chk_m) |-> (!crc_ok_o && !crc_err_o));

    // R3: completion is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3: results hold between completions
    a_r3_hold_results: assert property (@(posedge clk) disable iff (rst || !armed)
        !done_o |-> ($stable(crc_o) && $stable(frame_o)));

    // R10: loaded word completes on the FRAME_W-th edge after the load edge
    a_r10_word_latency: assert property (@(posedge clk) disable iff (rst)
        (wrun && wcnt == CNT_W'(FRAME_W)) |-> done_o);

endmodule

bind crc4_frame_seal crc4_frame_seal_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .mode_chk_i  (mode_chk_i),
    .word_load_i (word_load_i),
    .crc_o       (crc_o),
    .done_o      (done_o),
    .frame_o     (frame_o),
    .crc_ok_o    (crc_ok_o),
    .crc_err_o   (crc_err_o)
);

// File: tb/sim_crc4_frame_seal.sv
module sim_crc4_frame_seal;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        mode_chk_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        bit_vld_i = 1'b0;
    logic        word_load_i = 1'b0;
    logic [31:0] word_i = '0;
    logic [3:0]  crc_o;
    logic        done_o;
    logic [31:0] frame_o;
    logic        crc_ok_o;
    logic        crc_err_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit ended  = 1'b0;

    logic cap_done, cap_ok, cap_err;

    crc4_frame_seal #(.FRAME_W(32)) u0 (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .mode_chk_i  (mode_chk_i),
        .bit_i       (bit_i),
        .bit_vld_i   (bit_vld_i),
        .word_load_i (word_load_i),
        .word_i      (word_i),
        .crc_o       (crc_o),
        .done_o      (done_o),
        .frame_o     (frame_o),
        .crc_ok_o    (crc_ok_o),
        .crc_err_o   (crc_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    function automatic logic [3:0] ref_crc(input logic [31:0] w);
        logic [3:0] r;
        r = 4'hF;
        for (int i = 31; i >= 0; i--) begin
            logic b;
            logic f;
            b = (i < 4) ? 1'b0 : w[i];
            f = b ^ r[3];
            r = {r[2], r[1], r[0] ^ f, f};
        end
        return r;
    endfunction

    int          m_src;      // 0 none, 1 serial, 2 word
    bit          m_chk;
    logic [31:0] m_word;
    bit          mq[$];
    logic [3:0]  exp_crc;
    logic [31:0] exp_frame;
    logic        exp_done, exp_ok, exp_err;

    always @(posedge clk) begin
        if (rst) begin
            m_src = 0; m_chk = 0; m_word = '0; mq.delete();
            exp_crc = '0; exp_frame = '0;
            exp_done = 0; exp_ok = 0; exp_err = 0;
        end else begin
            exp_done = 0; exp_ok = 0; exp_err = 0;
            if (word_load_i) begin
                m_src = 2; m_word = word_i; m_chk = mode_chk_i; mq.delete();
            end else begin
                if (start_i) begin
                    m_src = 1; m_chk = mode_chk_i; mq.delete();
                end
                if (m_src == 1 && bit_vld_i) begin
                    mq.push_back(bit_i);
                end else if (m_src == 2) begin
                    mq.push_back(m_word[31]);
                    m_word = m_word << 1;
                end
            end
            if (mq.size() == 32) begin
                logic [31:0] w;
                for (int i = 0; i < 32; i++) w[31-i] = mq[i];
                exp_crc   = ref_crc(w);
                exp_frame = {w[31:4], exp_crc};
                exp_done  = 1;
                exp_ok    = m_chk && (w[3:0] == exp_crc);
                exp_err   = m_chk && (w[3:0] != exp_crc);
                m_src = 0;
                mq.delete();
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (cmp_en) begin
            check("R3 done_o",    32'(done_o),    32'(exp_done));
            check("R2 crc_o",     32'(crc_o),     32'(exp_crc));
            check("R4 frame_o",   frame_o,        exp_frame);
            check("R6 crc_ok_o",  32'(crc_ok_o),  32'(exp_ok));
            check("R6 crc_err_o", 32'(crc_err_o), 32'(exp_err));
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        start_i = 0; bit_vld_i = 0; word_load_i = 0; bit_i = 0;
    endtask

    task automatic send_serial(input logic [31:0] w, input logic chk,
                               input bit joint, input bit gaps);
        int first;
        tick();
        start_i = 1; mode_chk_i = chk; word_load_i = 0;
        bit_vld_i = joint; bit_i = joint ? w[31] : 1'b0;
        first = joint ? 30 : 31;
        for (int i = first; i >= 0; i--) begin
            if (gaps && (i % 3 == 0)) begin
                tick();
                start_i = 0; bit_vld_i = 0; bit_i = ~bit_i;
            end
            tick();
            start_i = 0; bit_vld_i = 1; bit_i = w[i];
        end
        tick();
        quiet();
        cap_done = done_o; cap_ok = crc_ok_o; cap_err = crc_err_o;
    endtask

    task automatic send_word(input logic [31:0] w, input logic chk,
                             input bit with_start, input bit noise);
        tick();
        word_load_i = 1; word_i = w; mode_chk_i = chk;
        start_i = with_start; bit_vld_i = noise; bit_i = 1;
        for (int k = 1; k <= 32; k++) begin
            tick();
            word_load_i = 0; start_i = 0;
            bit_vld_i = noise ? k[0] : 1'b0; bit_i = ~bit_i;
        end
        tick();
        quiet();
        cap_done = done_o; cap_ok = crc_ok_o; cap_err = crc_err_o;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1 done_o",    32'(done_o),    0);
        check("R1 crc_o",     32'(crc_o),     0);
        check("R1 frame_o",   frame_o,        0);
        check("R1 crc_ok_o",  32'(crc_ok_o),  0);
        check("R1 crc_err_o", 32'(crc_err_o), 0);
        cmp_en = 1;

        // R9: stray bits after reset, no frame open
        for (int i = 0; i < 5; i++) begin
            tick(); bit_vld_i = 1; bit_i = i[0];
        end
        tick(); quiet();
        tick();
        check("R9 no done after stray bits", 32'(done_o), 0);

        // R5: reference vectors
        send_serial(32'h007D8300, 0, 0, 0);
        check("R5 done",  32'(cap_done), 1);
        check("R5 crc 007D8300", 32'(crc_o), 32'h3);
        check("R5 frame 007D8303", frame_o, 32'h007D8303);
        check("R6 gen mode no ok", 32'(cap_ok), 0);

        // R8: start and first bit together
        send_serial(32'h0F000400, 0, 1, 0);
        check("R8 crc with joint start", 32'(crc_o), 32'h7);
        check("R5 frame 0F000407", frame_o, 32'h0F000407);

        // R4: low nibble ignored
        send_serial(32'h0F00040F, 0, 0, 0);
        check("R4 nibble ignored crc", 32'(crc_o), 32'h7);
        check("R4 nibble replaced", frame_o, 32'h0F000407);

        // R6: check mode good and bad
        send_serial(32'h007D8303, 1, 0, 0);
        check("R6 ok on match",   32'(cap_ok),  1);
        check("R6 no err on match", 32'(cap_err), 0);
        send_serial(32'h007D830A, 1, 1, 0);
        check("R6 err on mismatch", 32'(cap_err), 1);
        check("R6 no ok on mismatch", 32'(cap_ok), 0);

        // R7: abort partial frame with a new start
        tick(); start_i = 1; mode_chk_i = 0; bit_vld_i = 1; bit_i = 1;
        for (int i = 0; i < 12; i++) begin
            tick(); start_i = 0; bit_vld_i = 1; bit_i = 1;
        end
        send_serial(32'h007D8300, 0, 0, 0);
        check("R7 restart discards partial", 32'(crc_o), 32'h3);

        // R9: stray bits after completion leave outputs untouched
        for (int i = 0; i < 40; i++) begin
            tick(); bit_vld_i = 1; bit_i = i[1];
        end
        tick(); quiet();
        check("R9 crc held after stray bits", 32'(crc_o), 32'h3);

        // R11: gaps inside a serial frame
        send_serial(32'hDEADBEEF, 0, 0, 1);
        check("R11 gaps crc", 32'(crc_o), 32'(ref_crc(32'hDEADBEEF)));

        // R10: word mode, with start in same cycle and bit noise (R9)
        send_word(32'h0F000400, 0, 1, 1);
        check("R10 word done", 32'(cap_done), 1);
        check("R10 word crc", 32'(crc_o), 32'h7);
        send_word(32'h007D8303, 1, 0, 0);
        check("R10 word check ok", 32'(cap_ok), 1);

        // R10: word load aborts an open serial frame
        tick(); start_i = 1; mode_chk_i = 0; bit_vld_i = 1; bit_i = 1;
        for (int i = 0; i < 9; i++) begin
            tick(); start_i = 0; bit_vld_i = 1; bit_i = 0;
        end
        send_word(32'h12345678, 0, 0, 0);
        check("R10 word aborts serial", 32'(crc_o), 32'(ref_crc(32'h12345678)));

        // mixed random frames, compared every cycle
        for (int n = 0; n < 24; n++) begin
            logic [31:0] w;
            int kind;
            w = $urandom;
            kind = $urandom % 4;
            case (kind)
                0: send_serial(w, 1'($urandom % 2), 0, 0);
                1: send_serial(w, 1'($urandom % 2), 1, 1);
                2: send_word(w, 1'($urandom % 2), 0, 1);
                default: send_word(w, 1'($urandom % 2), 1, 0);
            endcase
            check("R2 random frame crc", 32'(crc_o), 32'(ref_crc(w)));
        end

        repeat (3) tick();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule